// File: doc/BRIEF.md
# SMBus Slave Packet Error Check Engine

This block runs the packet error check for the target side of a two-wire SMBus link. Bit-level bus logic elsewhere gives it one strobe per data bit, with the bit value. The acknowledge slot is not strobed. The block keeps a CRC-8 that advances on every strobed bit, starting with the address byte. It also counts down a loaded number of data bytes to find the check byte.

When the target is sending, the block supplies the check byte after the last counted data byte. When the target is receiving, it treats the byte after the counted data as the check byte and compares it with its own value. From that comparison it gives an acknowledge or not-acknowledge decision and records mismatches in a sticky error flag.

The CRC survives a repeated start, so one check can cover a combined write-then-read message. It is zeroed only by an explicit clear or by reset.

Top module: `smbus_pec_slave`

## Requirements
- R1: After reset `pec_phase`, `pec_bit`, `verdict_vld`, `verdict_nak` and `err_flag` are all 0, and the CRC is 0x00.
- R2: The CRC is CRC-8 with polynomial 0x07 (x^8+x^2+x+1) and initial value 0x00. It shifts MSB first with no final XOR, and it advances once per `bit_stb` on every bit of every byte, the address byte included.
- R3: The first 8 strobed bits after `frame_start` form the address byte and are not counted as data. Its last bit (bit 0) sets the direction: 1 means the target transmits, 0 means it receives.
- R4: `cnt_load` loads `cnt_val` as the number of data bytes. Each completed data byte decrements the count, and the check byte is not counted. With checking on, the check-byte phase starts right after the byte that exhausts the count, or right after the address byte when the count is 0.
- R5: When transmitting in the check-byte phase, `pec_phase` is 1 and `pec_bit` shows the CRC value captured at the end of the preceding bit, MSB first. The next bit is presented after each strobe, and `pec_bit` is stable between strobes.
- R6: When receiving, in the clock cycle after the edge that takes the 8th check-byte bit, `verdict_vld` pulses for one cycle. `verdict_nak` is then 0 if the received byte equals the captured CRC, and 1 otherwise.
- R7: `err_flag` is set by a not-acknowledge verdict and stays set through later matching checks. It is cleared only by an `err_clr` strobe, and a new mismatch in the same cycle wins over the clear.
- R8: With `pec_en` at 0 when the count is exhausted, no check-byte phase follows: `pec_phase` stays 0, no verdict is given, and later bytes are ignored.
- R9: `frame_start` with `crc_clr` at 0 keeps the running CRC, so a repeated-start transfer continues the same check. `crc_clr` zeroes it.
- R10: A transmit-direction transfer never produces a `verdict_vld` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pec_en | input | 1 | Enables check-byte insertion and checking |
| crc_clr | input | 1 | Zeroes the running CRC |
| frame_start | input | 1 | START or repeated START seen; next byte is the address |
| bit_stb | input | 1 | One data bit is on the bus this cycle |
| bit_val | input | 1 | Value of the strobed bit |
| cnt_load | input | 1 | Load the data-byte count |
| cnt_val | input | CNT_W | Number of data bytes before the check byte |
| err_clr | input | 1 | Write-one-to-clear for `err_flag` |
| pec_phase | output | 1 | Target is sending the check byte |
| pec_bit | output | 1 | Check-byte bit to drive while `pec_phase` is 1 |
| verdict_vld | output | 1 | One-cycle pulse: receive check finished |
| verdict_nak | output | 1 | 1 = mismatch, answer NAK; 0 = answer ACK |
| err_flag | output | 1 | Sticky check error |

## Verification
The CRC is tried with write messages of two data bytes, zero data bytes and one data byte. Matching check bytes must give ACK, and a check byte with one flipped bit must give NAK and set the error. A three-byte read shows that the check byte is inserted only after the count runs out. A write followed by a repeated-start read must send the CRC over all four bytes, which a per-byte or per-transfer restart would get wrong. Runs with checking off, with and without a clear after a dirty transfer, separate the enable and clear paths from the data path.

// File: rtl/smb_pec_pkg.sv
package smb_pec_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_DATA,
      PH_CHECK,
      PH_DONE
   } pec_phase_e;
endpackage

// File: rtl/smb_crc_serial.sv
module smb_crc_serial #(
   parameter int unsigned      W    = 8,
   parameter logic [W-1:0]     POLY = 8'h07,
   parameter logic [W-1:0]     INIT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         stb,
   input  logic         din,
   output logic [W-1:0] crc_nxt
);
   logic [W-1:0] crc_q;
   logic [W-1:0] shifted;
   logic         fb;

   always_comb begin
      fb      = crc_q[W-1] ^ din;
      shifted = {crc_q[W-2:0], 1'b0};
      if (stb) crc_nxt = fb ? (shifted ^ POLY) : shifted;
      else     crc_nxt = crc_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc_q <= INIT;
      else if (clr) crc_q <= INIT;
      else          crc_q <= crc_nxt;
   end
endmodule

// File: rtl/smb_pec_seq.sv
module smb_pec_seq
   import smb_pec_pkg::*;
#(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned CNT_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic             bit_stb,
   input  logic             bit_val,
   input  logic             cnt_load,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic             pec_en,
   output pec_phase_e       phase,
   output logic             slave_tx,
   output logic             enter_check,
   output logic             check_done
);
   localparam int unsigned IDX_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BYTE_W - 1);
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   pec_phase_e       phase_n;
   logic [IDX_W-1:0] idx_q;
   logic [CNT_W-1:0] cnt_q, cnt_n;
   logic             byte_end;
   logic             counting;

   assign counting = (phase == PH_ADDR) || (phase == PH_DATA) || (phase == PH_CHECK);
   assign byte_end = bit_stb && counting && (idx_q == IDX_LAST);

   always_comb begin
      phase_n     = phase;
      cnt_n       = cnt_q;
      enter_check = 1'b0;
      check_done  = 1'b0;
      if (frame_start) begin
         phase_n = PH_ADDR;
      end else if (byte_end) begin
         case (phase)
            PH_ADDR: begin
               if (cnt_q != '0) phase_n = PH_DATA;
               else if (pec_en) begin
                  phase_n     = PH_CHECK;
                  enter_check = 1'b1;
               end else phase_n = PH_DONE;
            end
            PH_DATA: begin
               if (cnt_q <= CNT_ONE) begin
                  cnt_n = '0;
                  if (pec_en) begin
                     phase_n     = PH_CHECK;
                     enter_check = 1'b1;
                  end else phase_n = PH_DONE;
               end else cnt_n = cnt_q - CNT_ONE;
            end
            PH_CHECK: begin
               check_done = 1'b1;
               phase_n    = PH_DONE;
            end
            default: phase_n = phase;
         endcase
      end
      if (cnt_load) cnt_n = cnt_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         cnt_q    <= '0;
         idx_q    <= '0;
         slave_tx <= 1'b0;
      end else begin
         phase <= phase_n;
         cnt_q <= cnt_n;
         if (frame_start)          idx_q <= '0;
         else if (byte_end)        idx_q <= '0;
         else if (bit_stb && counting) idx_q <= idx_q + IDX_W'(1);
         if (byte_end && phase == PH_ADDR && !frame_start) slave_tx <= bit_val;
      end
   end
endmodule

// File: rtl/smb_pec_judge.sv
module smb_pec_judge #(
   parameter int unsigned W       = 8,
   parameter bit          RESIDUE = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bit_stb,
   input  logic         bit_val,
   input  logic         in_check,
   input  logic         enter_check,
   input  logic         check_done,
   input  logic         slave_tx,
   input  logic [W-1:0] crc_nxt,
   input  logic         err_clr,
   output logic         pec_phase,
   output logic         pec_bit,
   output logic         verdict_vld,
   output logic         verdict_nak,
   output logic         err_flag
);
   logic [W-1:0] snap_q;
   logic         miss_q;
   logic         mism;
   logic         rx_fail;

   generate
      if (RESIDUE) begin : g_residue
         assign mism = (crc_nxt != '0);
      end else begin : g_compare
         assign mism = miss_q | (bit_val != snap_q[W-1]);
      end
   endgenerate

   assign pec_phase = in_check && slave_tx;
   assign pec_bit   = pec_phase && snap_q[W-1];
   assign rx_fail   = check_done && !slave_tx && mism;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_q      <= '0;
         miss_q      <= 1'b0;
         verdict_vld <= 1'b0;
         verdict_nak <= 1'b0;
         err_flag    <= 1'b0;
      end else begin
         if (enter_check) begin
            snap_q <= crc_nxt;
            miss_q <= 1'b0;
         end else if (in_check && bit_stb) begin
            snap_q <= {snap_q[W-2:0], 1'b0};
            miss_q <= miss_q | (bit_val != snap_q[W-1]);
         end
         verdict_vld <= check_done && !slave_tx;
         if (check_done && !slave_tx) verdict_nak <= mism;
         if (rx_fail)      err_flag <= 1'b1;
         else if (err_clr) err_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/smbus_pec_slave.sv
module smbus_pec_slave
   import smb_pec_pkg::*;
#(
   parameter int unsigned           BYTE_W  = 8,
   parameter logic [BYTE_W-1:0]     POLY    = 8'h07,
   parameter int unsigned           CNT_W   = 8,
   parameter bit                    RESIDUE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pec_en,
   input  logic             crc_clr,
   input  logic             frame_start,
   input  logic             bit_stb,
   input  logic             bit_val,
   input  logic             cnt_load,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic             err_clr,
   output logic             pec_phase,
   output logic             pec_bit,
   output logic             verdict_vld,
   output logic             verdict_nak,
   output logic             err_flag
);
   initial begin
      assert (BYTE_W >= 2) else $error("BYTE_W must be at least 2");
      assert (CNT_W >= 1)  else $error("CNT_W must be at least 1");
      assert (POLY[0])     else $error("POLY must have its constant term set");
   end

   logic [BYTE_W-1:0] crc_nxt;
   pec_phase_e        phase;
   logic              slave_tx, enter_check, check_done;

   smb_crc_serial #(.W(BYTE_W), .POLY(POLY), .INIT('0)) u_crc (
      .clk(clk), .rst_n(rst_n), .clr(crc_clr), .stb(bit_stb),
      .din(bit_val), .crc_nxt(crc_nxt)
   );

   smb_pec_seq #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .bit_stb(bit_stb),
      .bit_val(bit_val), .cnt_load(cnt_load), .cnt_val(cnt_val), .pec_en(pec_en),
      .phase(phase), .slave_tx(slave_tx), .enter_check(enter_check),
      .check_done(check_done)
   );

   smb_pec_judge #(.W(BYTE_W), .RESIDUE(RESIDUE)) u_judge (
      .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
      .in_check(phase == PH_CHECK), .enter_check(enter_check),
      .check_done(check_done), .slave_tx(slave_tx), .crc_nxt(crc_nxt),
      .err_clr(err_clr), .pec_phase(pec_phase), .pec_bit(pec_bit),
      .verdict_vld(verdict_vld), .verdict_nak(verdict_nak), .err_flag(err_flag)
   );
endmodule

// File: rtl/smbus_pec_slave_chk.sv
module smbus_pec_slave_chk (
   input logic clk,
   input logic rst_n,
   input logic pec_en,
   input logic frame_start,
   input logic bit_stb,
   input logic err_clr,
   input logic pec_phase,
   input logic pec_bit,
   input logic verdict_vld,
   input logic verdict_nak,
   input logic err_flag
);
   a_r7_err_needs_nak: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flag) |-> (verdict_vld && verdict_nak));

   a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !err_clr) |=> err_flag);

   a_r6_verdict_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      verdict_vld |=> !verdict_vld);

   a_r8_check_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pec_phase) |-> $past(pec_en));

   a_r5_bit_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (pec_phase && !bit_stb && !frame_start) |=> $stable(pec_bit));

   a_r10_no_tx_verdict: assert property (@(posedge clk) disable iff (!rst_n)
      (pec_phase && bit_stb) |=> !verdict_vld);
endmodule

bind smbus_pec_slave smbus_pec_slave_chk u_chk (
   .clk(clk), .rst_n(rst_n), .pec_en(pec_en), .frame_start(frame_start),
   .bit_stb(bit_stb), .err_clr(err_clr), .pec_phase(pec_phase),
   .pec_bit(pec_bit), .verdict_vld(verdict_vld), .verdict_nak(verdict_nak),
   .err_flag(err_flag)
);

// File: tb/smbus_pec_slave_test.sv
module smbus_pec_slave_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pec_en = 1'b0, crc_clr = 1'b0, frame_start = 1'b0;
   logic       bit_stb = 1'b0, bit_val = 1'b0, cnt_load = 1'b0, err_clr = 1'b0;
   logic [7:0] cnt_val = '0;
   logic       pec_phase, pec_bit, verdict_vld, verdict_nak, err_flag;

   int n_chk = 0;
   int n_bad = 0;
   int n_verdict = 0;

   always #10 clk = ~clk;

   smbus_pec_slave uut (
      .clk(clk), .rst_n(rst_n), .pec_en(pec_en), .crc_clr(crc_clr),
      .frame_start(frame_start), .bit_stb(bit_stb), .bit_val(bit_val),
      .cnt_load(cnt_load), .cnt_val(cnt_val), .err_clr(err_clr),
      .pec_phase(pec_phase), .pec_bit(pec_bit), .verdict_vld(verdict_vld),
      .verdict_nak(verdict_nak), .err_flag(err_flag)
   );

   always @(posedge clk) if (verdict_vld) n_verdict++;

   function automatic logic [7:0] crc_add(input logic [7:0] c, input logic [7:0] b);
      logic [7:0] r = c;
      for (int i = 7; i >= 0; i--) begin
         logic fb = r[7] ^ b[i];
         r = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
      end
      return r;
   endfunction

   task automatic chk(input string req, input int act, input int exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic put_bit(input logic v);
      bit_stb = 1'b1; bit_val = v;
      @(negedge clk);
      bit_stb = 1'b0; bit_val = 1'b0;
   endtask

   task automatic put_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) put_bit(b[i]);
   endtask

   task automatic begin_frame(input logic clr);
      frame_start = 1'b1; crc_clr = clr;
      @(negedge clk);
      frame_start = 1'b0; crc_clr = 1'b0;
   endtask

   task automatic load_count(input logic [7:0] n);
      cnt_load = 1'b1; cnt_val = n;
      @(negedge clk);
      cnt_load = 1'b0;
   endtask

   task automatic take_check_byte(output logic [7:0] got);
      for (int i = 7; i >= 0; i--) begin
         got[i] = pec_bit;
         put_bit(pec_bit);
      end
   endtask

   task automatic t_reset;
      chk("R1", pec_phase, 0, "pec_phase after reset");
      chk("R1", pec_bit, 0, "pec_bit after reset");
      chk("R1", verdict_vld, 0, "verdict_vld after reset");
      chk("R1", verdict_nak, 0, "verdict_nak after reset");
      chk("R1", err_flag, 0, "err_flag after reset");
   endtask

   task automatic t_write(input logic [7:0] flip, input int exp_nak, input int exp_err,
                          input string req);
      logic [7:0] c = 8'h00;
      pec_en = 1'b1;
      begin_frame(1'b1);
      load_count(8'd2);
      put_byte(8'hB4); c = crc_add(c, 8'hB4);
      put_byte(8'h12); c = crc_add(c, 8'h12);
      put_byte(8'h34); c = crc_add(c, 8'h34);
      chk("R3", pec_phase, 0, "receive direction drives no check byte");
      put_byte(c ^ flip);
      chk("R6", verdict_vld, 1, "verdict pulse after check byte");
      chk(req, verdict_nak, exp_nak, "write verdict");
      chk("R7", err_flag, exp_err, "error flag after write");
      @(negedge clk);
      chk("R6", verdict_vld, 0, "verdict pulse is one cycle");
   endtask

   task automatic t_clear_err;
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      chk("R7", err_flag, 0, "err_clr clears flag");
   endtask

   task automatic t_read_three;
      logic [7:0] c = 8'h00;
      logic [7:0] got;
      int v0 = n_verdict;
      pec_en = 1'b1;
      begin_frame(1'b1);
      load_count(8'd3);
      put_byte(8'hB5); c = crc_add(c, 8'hB5);
      put_byte(8'hA1); c = crc_add(c, 8'hA1);
      put_byte(8'h5C); c = crc_add(c, 8'h5C);
      chk("R4", pec_phase, 0, "no check byte before count exhausted");
      put_byte(8'h03); c = crc_add(c, 8'h03);
      chk("R4", pec_phase, 1, "check byte after third data byte");
      take_check_byte(got);
      chk("R5", got, c, "transmitted check byte");
      chk("R5", pec_phase, 0, "check phase ends after 8 bits");
      @(negedge clk);
      chk("R10", n_verdict - v0, 0, "no verdict in transmit");
   endtask

   task automatic t_disabled;
      int v0 = n_verdict;
      pec_en = 1'b0;
      begin_frame(1'b1);
      load_count(8'd1);
      put_byte(8'hB5);
      put_byte(8'h55);
      chk("R8", pec_phase, 0, "no check byte when disabled");
      begin_frame(1'b1);
      load_count(8'd1);
      put_byte(8'hB4);
      put_byte(8'h55);
      put_byte(8'h99);
      @(negedge clk);
      chk("R8", n_verdict - v0, 0, "no verdict when disabled");
   endtask

   task automatic t_zero_count;
      pec_en = 1'b1;
      begin_frame(1'b1);
      load_count(8'd0);
      put_byte(8'hB4);
      put_byte(crc_add(8'h00, 8'hB4));
      chk("R4", verdict_vld, 1, "zero count: check right after address");
      chk("R2", verdict_nak, 0, "zero count CRC over address byte");
      @(negedge clk);
   endtask

   task automatic t_linked;
      logic [7:0] c = 8'h00;
      logic [7:0] got;
      pec_en = 1'b0;
      begin_frame(1'b1);
      load_count(8'd1);
      put_byte(8'hB4); c = crc_add(c, 8'hB4);
      put_byte(8'h08); c = crc_add(c, 8'h08);
      pec_en = 1'b1;
      begin_frame(1'b0);
      load_count(8'd1);
      put_byte(8'hB5); c = crc_add(c, 8'hB5);
      put_byte(8'hC7); c = crc_add(c, 8'hC7);
      chk("R3", pec_phase, 1, "read bit selects transmit");
      take_check_byte(got);
      chk("R9", got, c, "CRC carried over repeated start");
   endtask

   task automatic t_clear_crc;
      pec_en = 1'b0;
      begin_frame(1'b1);
      load_count(8'd1);
      put_byte(8'hB4);
      put_byte(8'h11);
      pec_en = 1'b1;
      begin_frame(1'b1);
      load_count(8'd0);
      put_byte(8'hB4);
      put_byte(crc_add(8'h00, 8'hB4));
      chk("R9", verdict_nak, 0, "crc_clr restarts CRC from zero");
      @(negedge clk);
   endtask

   initial begin
      #(20 * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write(8'h00, 0, 0, "R6");
      t_write(8'h01, 1, 1, "R6");
      t_write(8'h00, 0, 1, "R7");
      t_clear_err();
      t_read_three();
      t_disabled();
      t_zero_count();
      t_linked();
      t_clear_crc();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule